// File: doc/BRIEF.md
# Delta-panel timing generator

This block turns a horizontal sync and a vertical sync into the drive pulses that a delta-arranged active-matrix LCD panel needs. On the horizontal side it makes a line start pulse and a pair of complementary sample clocks, which run for a set number of periods after each start. On the vertical side it makes a frame start pulse, a pair of complementary line clocks that advance the gate selection once per line, a gate-enable pulse and a precharge pulse placed at fixed offsets after each line-clock edge.

The panel's dots on neighbouring rows sit one and a half dots apart. To follow this, the horizontal start and its clocks are pushed back by one and a half sample-clock periods on every second line. A polarity flag flips on every line for the video inversion. In narrow (4:3) mode a side-black flag marks the parts of the line where no sample clock runs, and the sweep is shorter. Three mode inputs set aspect, horizontal direction and vertical direction. They are taken in at each vertical sync and hold for the whole frame. They also set the sampling phases given to the second and third colour channels.

Every delay and count is a parameter in system-clock cycles. The generator restarts its horizontal timing at every horizontal sync edge.

Top module: `dpt_timing_gen`

## Requirements
- R1: A rising edge of `hsync_i` seen at clock edge k starts the sweep: on a line with no shift, `hck1_o` first goes high after edge k+HST_DLY. `hst_o` is high for exactly the first sample-clock period, which is 2*HCK_HALF cycles. In the cycle after the edge, both `hck1_o` and `hst_o` are low.
- R2: Lines alternate between no shift and a shift of 3*HCK_HALF extra cycles (one and a half periods). The first line after a vertical sync edge has no shift.
- R3: `hck1_o` is high for HCK_HALF cycles and then low for HCK_HALF cycles. `hck2_o` is always its complement. `hck1_o` is low outside the sweep. A sweep has H_WIDE periods when `wide_o`=1 and H_NARROW periods when `wide_o`=0.
- R4: A vertical sync edge clears `vck1_o` to 0, and `vck2_o` is always its complement. Each of the first LINES horizontal sync edges after that toggles `vck1_o`. Later edges in the same frame leave it unchanged. `vst_o` is high from the first horizontal sync edge after vertical sync up to the second.
- R5: `gate_en_o` goes high EN_DLY cycles after each line-clock toggle and stays high for EN_W cycles. `pchg_o` goes high PCG_DLY cycles after the toggle and stays high for PCG_W cycles. The two never overlap, and `pchg_o` is low at every toggle. Lines with no toggle get neither pulse.
- R6: `line_pol_o` is 0 after reset and flips on every horizontal sync edge, including lines after the last active line.
- R7: `wide_o`, `right_o` and `down_o` take the values of `wide_i`, `right_i` and `down_i` at each vertical sync edge. They reset to 1. Changes to the inputs between vertical syncs have no effect on them.
- R8: `side_black_o` is high when `wide_o`=0 and no sweep is running. It is low during the sweep and always low when `wide_o`=1.
- R9: In right scan (`right_o`=1), `ch2_phase_o`=1 and `ch3_phase_o`=2. In left scan, the two codes are swapped (2 and 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, rising edge starts a line |
| vsync_i | input | 1 | Vertical sync, rising edge starts a frame |
| wide_i | input | 1 | Aspect select: 1 = 16:9, 0 = 4:3 |
| right_i | input | 1 | Horizontal direction: 1 = right scan |
| down_i | input | 1 | Vertical direction: 1 = down scan |
| hst_o | output | 1 | Horizontal start pulse |
| hck1_o | output | 1 | Sample clock, phase 1 |
| hck2_o | output | 1 | Sample clock, phase 2 |
| vst_o | output | 1 | Vertical start pulse |
| vck1_o | output | 1 | Line clock, phase 1 |
| vck2_o | output | 1 | Line clock, phase 2 |
| gate_en_o | output | 1 | Gate enable pulse |
| pchg_o | output | 1 | Precharge pulse |
| line_pol_o | output | 1 | Per-line video polarity |
| side_black_o | output | 1 | Side-black window in 4:3 mode |
| wide_o | output | 1 | Latched aspect mode |
| right_o | output | 1 | Latched horizontal direction |
| down_o | output | 1 | Latched vertical direction |
| ch2_phase_o | output | 2 | Sampling phase code for colour channel 2 |
| ch3_phase_o | output | 2 | Sampling phase code for colour channel 3 |

## Verification
The assertions rely on the sync inputs keeping out of each other's way:
- A vertical sync edge never falls in the same cycle as a horizontal sync edge.
- Each line is longer than the shifted start delay plus a full sweep plus the precharge window, so that `pchg_o` has ended before the next line-clock toggle.
- The parameters keep PCG_DLY at least EN_DLY+EN_W.

The stimulus respects all of this. Vertical sync is driven only after a line has finished its sweep. Every line lasts a fixed 80 cycles, longer than the worst shifted sweep in either aspect. The mode inputs are changed only just before a vertical sync, or in mid-frame on purpose, to show that they are ignored there.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  typedef enum logic [1:0] {
    H_IDLE,
    H_WAIT,
    H_RUN
  } hstate_t;

  // cycles from the sync edge to the first sample-clock high cycle
  function automatic int unsigned start_delay(input int unsigned base,
                                              input int unsigned half,
                                              input logic shifted);
    return shifted ? base + 3 * half : base;
  endfunction

  // sample-clock periods in one sweep for the chosen aspect
  function automatic int unsigned line_periods(input int unsigned wide_n,
                                               input int unsigned narrow_n,
                                               input logic wide);
    return wide ? wide_n : narrow_n;
  endfunction

  // right scan: channel 2 -> 1, channel 3 -> 2; left scan swaps them
  function automatic logic [1:0] phase_code(input logic right, input logic chan2);
    return (right ~^ chan2) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/dpt_edge.sv
module dpt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dpt_hsweep.sv
module dpt_hsweep
  import dpt_pkg::*;
#(
  parameter int unsigned HCK_HALF = 7,
  parameter int unsigned HST_DLY  = 8,
  parameter int unsigned H_WIDE   = 357,
  parameter int unsigned H_NARROW = 269
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise,
  input  logic vs_rise,
  input  logic wide,
  output logic hck1,
  output logic hck2,
  output logic hst,
  output logic run
);
  localparam int unsigned MAXD = HST_DLY + 3 * HCK_HALF;
  localparam int unsigned DW   = $clog2(MAXD + 1);
  localparam int unsigned PHW  = (HCK_HALF > 1) ? $clog2(2 * HCK_HALF) : 1;
  localparam int unsigned PW   = $clog2(H_WIDE + 1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(2 * HCK_HALF - 1);
  localparam logic [PHW-1:0] PH_HALF = PHW'(HCK_HALF);

  hstate_t        st_q;
  logic [DW-1:0]  dly_q;
  logic [PHW-1:0] ph_q;
  logic [PW-1:0]  per_q;
  logic [PW-1:0]  nper_q;
  logic           odd_q;
  logic           odd_nx;

  assign odd_nx = ~odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= H_IDLE;
      dly_q  <= '0;
      ph_q   <= '0;
      per_q  <= '0;
      nper_q <= PW'(H_WIDE);
      odd_q  <= 1'b1;
    end else if (vs_rise) begin
      st_q  <= H_IDLE;
      odd_q <= 1'b1;
    end else if (hs_rise) begin
      st_q   <= H_WAIT;
      odd_q  <= odd_nx;
      dly_q  <= DW'(start_delay(HST_DLY, HCK_HALF, odd_nx) - 1);
      nper_q <= PW'(line_periods(H_WIDE, H_NARROW, wide));
      ph_q   <= '0;
      per_q  <= '0;
    end else begin
      unique case (st_q)
        H_WAIT: begin
          if (dly_q == '0) begin
            st_q  <= H_RUN;
            ph_q  <= '0;
            per_q <= '0;
          end else begin
            dly_q <= dly_q - 1'b1;
          end
        end
        H_RUN: begin
          if (ph_q == PH_LAST) begin
            ph_q <= '0;
            if (per_q == nper_q - 1'b1) st_q <= H_IDLE;
            else                        per_q <= per_q + 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign run  = (st_q == H_RUN);
  assign hck1 = run && (ph_q < PH_HALF);
  assign hck2 = ~hck1;
  assign hst  = run && (per_q == '0);
endmodule

// File: rtl/dpt_vscan.sv
module dpt_vscan #(
  parameter int unsigned LINES   = 225,
  parameter int unsigned EN_DLY  = 40,
  parameter int unsigned EN_W    = 200,
  parameter int unsigned PCG_DLY = 300,
  parameter int unsigned PCG_W   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise,
  input  logic vs_rise,
  output logic vck1,
  output logic vck2,
  output logic vst,
  output logic gate_en,
  output logic pchg
);
  localparam int unsigned LW   = $clog2(LINES + 1);
  localparam int unsigned TMAX = PCG_DLY + PCG_W;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [LW-1:0] LC_END = LW'(LINES);
  localparam logic [LW-1:0] LC_ONE = LW'(1);
  localparam logic [TW-1:0] T_TOP  = TW'(TMAX);
  localparam logic [TW-1:0] EN_LO  = TW'(EN_DLY);
  localparam logic [TW-1:0] EN_HI  = TW'(EN_DLY + EN_W);
  localparam logic [TW-1:0] PC_LO  = TW'(PCG_DLY);
  localparam logic [TW-1:0] PC_HI  = TW'(PCG_DLY + PCG_W);

  logic [LW-1:0] lc_q;
  logic [TW-1:0] et_q;
  logic          tv_q;
  logic          vck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q  <= LC_END;
      et_q  <= '0;
      tv_q  <= 1'b0;
      vck_q <= 1'b0;
    end else if (vs_rise) begin
      lc_q  <= '0;
      et_q  <= '0;
      tv_q  <= 1'b0;
      vck_q <= 1'b0;
    end else if (hs_rise) begin
      if (lc_q < LC_END) begin
        lc_q  <= lc_q + 1'b1;
        vck_q <= ~vck_q;
        tv_q  <= 1'b1;
        et_q  <= '0;
      end else begin
        tv_q <= 1'b0;
      end
    end else if (tv_q && et_q != T_TOP) begin
      et_q <= et_q + 1'b1;
    end
  end

  assign vck1    = vck_q;
  assign vck2    = ~vck_q;
  assign vst     = (lc_q == LC_ONE);
  assign gate_en = tv_q && (et_q >= EN_LO) && (et_q < EN_HI);
  assign pchg    = tv_q && (et_q >= PC_LO) && (et_q < PC_HI);
endmodule

// File: rtl/dpt_timing_gen.sv
module dpt_timing_gen
  import dpt_pkg::*;
#(
  parameter int unsigned HCK_HALF = 7,
  parameter int unsigned HST_DLY  = 8,
  parameter int unsigned H_WIDE   = 357,
  parameter int unsigned H_NARROW = 269,
  parameter int unsigned LINES    = 225,
  parameter int unsigned EN_DLY   = 40,
  parameter int unsigned EN_W     = 200,
  parameter int unsigned PCG_DLY  = 300,
  parameter int unsigned PCG_W    = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       wide_i,
  input  logic       right_i,
  input  logic       down_i,
  output logic       hst_o,
  output logic       hck1_o,
  output logic       hck2_o,
  output logic       vst_o,
  output logic       vck1_o,
  output logic       vck2_o,
  output logic       gate_en_o,
  output logic       pchg_o,
  output logic       line_pol_o,
  output logic       side_black_o,
  output logic       wide_o,
  output logic       right_o,
  output logic       down_o,
  output logic [1:0] ch2_phase_o,
  output logic [1:0] ch3_phase_o
);
  // named internal events, also used by the bound checker
  logic hs_rise;
  logic vs_rise;
  logic h_run;
  logic wide_q, right_q, down_q, pol_q;

  logic [1:0] sync_lvl;
  logic [1:0] sync_rise;
  assign sync_lvl = {vsync_i, hsync_i};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    dpt_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (sync_lvl[g]),
      .rise_o(sync_rise[g])
    );
  end

  assign hs_rise = sync_rise[0];
  assign vs_rise = sync_rise[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b1;
      right_q <= 1'b1;
      down_q  <= 1'b1;
    end else if (vs_rise) begin
      wide_q  <= wide_i;
      right_q <= right_i;
      down_q  <= down_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pol_q <= 1'b0;
    else if (hs_rise) pol_q <= ~pol_q;
  end

  dpt_hsweep #(
    .HCK_HALF(HCK_HALF),
    .HST_DLY (HST_DLY),
    .H_WIDE  (H_WIDE),
    .H_NARROW(H_NARROW)
  ) u_hsweep (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_rise(hs_rise),
    .vs_rise(vs_rise),
    .wide   (wide_q),
    .hck1   (hck1_o),
    .hck2   (hck2_o),
    .hst    (hst_o),
    .run    (h_run)
  );

  dpt_vscan #(
    .LINES  (LINES),
    .EN_DLY (EN_DLY),
    .EN_W   (EN_W),
    .PCG_DLY(PCG_DLY),
    .PCG_W  (PCG_W)
  ) u_vscan (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_rise(hs_rise),
    .vs_rise(vs_rise),
    .vck1   (vck1_o),
    .vck2   (vck2_o),
    .vst    (vst_o),
    .gate_en(gate_en_o),
    .pchg   (pchg_o)
  );

  assign line_pol_o   = pol_q;
  assign side_black_o = ~wide_q & ~h_run;
  assign wide_o       = wide_q;
  assign right_o      = right_q;
  assign down_o       = down_q;
  assign ch2_phase_o  = phase_code(right_q, 1'b1);
  assign ch3_phase_o  = phase_code(right_q, 1'b0);
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
  input logic clk,
  input logic rst_n,
  input logic hs_rise,
  input logic vs_rise,
  input logic hck1,
  input logic hst,
  input logic vck1,
  input logic gate_en,
  input logic pchg,
  input logic line_pol,
  input logic wide,
  input logic right,
  input logic side_black
);
  AST_SWEEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (!hck1 && !hst)); // R1
  AST_HST_WITH_HCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hst) |-> $rose(hck1)); // R1
  AST_VCK_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (vck1 != $past(vck1)) |-> ($past(hs_rise) || $past(vs_rise))); // R4
  AST_NO_PCG_AT_VCK: assert property (@(posedge clk) disable iff (!rst_n)
    (vck1 != $past(vck1)) |-> !$past(pchg)); // R5
  AST_EN_PCG_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && pchg)); // R5
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> (line_pol != $past(line_pol))); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> ($stable(wide) && $stable(right))); // R7
  AST_SB_WIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> !side_black); // R8
  AST_SB_OFF_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    hck1 |-> !side_black); // R8
endmodule

bind dpt_timing_gen dpt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_rise   (hs_rise),
  .vs_rise   (vs_rise),
  .hck1      (hck1_o),
  .hst       (hst_o),
  .vck1      (vck1_o),
  .gate_en   (gate_en_o),
  .pchg      (pchg_o),
  .line_pol  (line_pol_o),
  .wide      (wide_o),
  .right     (right_o),
  .side_black(side_black_o)
);

// File: tb/sim_dpt_timing_gen.sv
module sim_dpt_timing_gen;
  localparam int HALF = 2, HDLY = 3, HW = 12, HN = 8, NL = 5;
  localparam int EDLY = 4, EW = 6, PDLY = 12, PW = 5, LINE_CYC = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0;
  logic wide_i = 1'b1, right_i = 1'b1, down_i = 1'b1;
  logic hst_o, hck1_o, hck2_o, vst_o, vck1_o, vck2_o, gate_en_o, pchg_o;
  logic line_pol_o, side_black_o, wide_o, right_o, down_o;
  logic [1:0] ch2_phase_o, ch3_phase_o;

  always #10 clk = ~clk;

  dpt_timing_gen #(
    .HCK_HALF(HALF), .HST_DLY(HDLY), .H_WIDE(HW), .H_NARROW(HN), .LINES(NL),
    .EN_DLY(EDLY), .EN_W(EW), .PCG_DLY(PDLY), .PCG_W(PW)
  ) u0 (.*);

  typedef struct {
    int hs_cyc; int dly; int nper; bit pol; bit vck; bit vst;
  } item_t;
  item_t q[$];

  int cyc = 0;
  int checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model state
  bit m_wide = 1, m_right = 1, m_down = 1, m_pol = 0, m_odd = 1, m_vck = 0;
  int m_lc = NL, exp_gate = 0, last_hs = -1000;
  bit mon_on = 0;

  task automatic do_line();
    item_t it;
    @(negedge clk);
    hsync_i = 1'b1;
    last_hs = cyc;
    m_pol = ~m_pol;
    m_odd = ~m_odd;
    if (m_lc < NL) begin
      m_lc++;
      m_vck = ~m_vck;
      exp_gate++;
    end
    it.hs_cyc = cyc;
    it.dly = HDLY + (m_odd ? 3 * HALF : 0);
    it.nper = m_wide ? HW : HN;
    it.pol = m_pol;
    it.vck = m_vck;
    it.vst = (m_lc == 1);
    q.push_back(it);
    @(negedge clk);
    hsync_i = 1'b0;
    repeat (LINE_CYC - 3) @(negedge clk);
    chk("R8", "side_black after sweep", side_black_o, !m_wide);
    @(negedge clk);
  endtask

  task automatic do_frame(input bit w, input bit r, input bit d, input int nlines);
    @(negedge clk);
    wide_i = w; right_i = r; down_i = d;
    vsync_i = 1'b1;
    m_wide = w; m_right = r; m_down = d;
    m_lc = 0; m_vck = 0; m_odd = 1;
    @(negedge clk);
    vsync_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "wide_o latched", wide_o, w);
    chk("R7", "right_o latched", right_o, r);
    chk("R7", "down_o latched", down_o, d);
    chk("R9", "ch2 phase", ch2_phase_o, r ? 1 : 2);
    chk("R9", "ch3 phase", ch3_phase_o, r ? 2 : 1);
    chk("R4", "vck1 cleared", vck1_o, 0);
    chk("R4", "vck2 complement", vck2_o, 1);
    chk("R4", "vst idle before first line", vst_o, 0);
    chk("R8", "side_black at frame start", side_black_o, !w);
    // changes between syncs must be ignored
    wide_i = ~w; right_i = ~r; down_i = ~d;
    for (int i = 0; i < nlines; i++) do_line();
    chk("R7", "wide_o held in frame", wide_o, w);
    chk("R7", "right_o held in frame", right_o, r);
    chk("R7", "down_o held in frame", down_o, d);
  endtask

  // monitor: pops expected line items as the sweeps appear
  item_t cur;
  bit have = 0, p_hst = 0, p_hck = 0, p_gate = 0, p_pchg = 0;
  int hck_cnt = 0, hi_len = 0, hst_len = 0, gate_len = 0, pchg_len = 0;
  int compl_err = 0, duty_err = 0, ovl_err = 0, gate_cnt = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (hck2_o === hck1_o) compl_err++;
      if (gate_en_o && pchg_o) ovl_err++;
      if (hst_o && !p_hst) begin
        if (have) chk("R3", "periods per sweep", hck_cnt, cur.nper);
        if (q.size() == 0) begin
          chk("R1", "unexpected sweep", 1, 0);
          have = 0;
        end else begin
          cur = q.pop_front();
          have = 1;
          chk(cur.dly != HDLY ? "R2" : "R1", "start delay", cyc - cur.hs_cyc - 1, cur.dly);
          chk("R6", "line polarity", line_pol_o, cur.pol);
          chk("R4", "vck1 level", vck1_o, cur.vck);
          chk("R4", "vst level", vst_o, cur.vst);
          chk("R8", "side_black in sweep", side_black_o, 0);
        end
        hck_cnt = 0;
        hst_len = 0;
      end
      if (hst_o) hst_len++;
      if (!hst_o && p_hst) chk("R1", "hst width", hst_len, 2 * HALF);
      if (hck1_o && !p_hck) begin
        hck_cnt++;
        hi_len = 0;
      end
      if (hck1_o) hi_len++;
      if (!hck1_o && p_hck && hi_len != HALF) duty_err++;
      if (gate_en_o && !p_gate) begin
        gate_cnt++;
        gate_len = 0;
        chk("R5", "gate_en delay", cyc - last_hs - 1, EDLY);
      end
      if (gate_en_o) gate_len++;
      if (!gate_en_o && p_gate) chk("R5", "gate_en width", gate_len, EW);
      if (pchg_o && !p_pchg) begin
        pchg_len = 0;
        chk("R5", "pchg delay", cyc - last_hs - 1, PDLY);
      end
      if (pchg_o) pchg_len++;
      if (!pchg_o && p_pchg) chk("R5", "pchg width", pchg_len, PW);
      p_hst = hst_o; p_hck = hck1_o; p_gate = gate_en_o; p_pchg = pchg_o;
    end
  end

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset hst", hst_o, 0);
    chk("R3", "reset hck1", hck1_o, 0);
    chk("R3", "reset hck2", hck2_o, 1);
    chk("R4", "reset vck1", vck1_o, 0);
    chk("R5", "reset gate_en", gate_en_o, 0);
    chk("R5", "reset pchg", pchg_o, 0);
    chk("R6", "reset polarity", line_pol_o, 0);
    chk("R7", "reset wide_o", wide_o, 1);
    chk("R9", "reset ch2 phase", ch2_phase_o, 1);
    mon_on = 1;
    do_frame(1, 1, 1, NL + 2);
    do_frame(0, 0, 0, NL + 1);
    do_frame(1, 0, 1, 3);
    do_frame(0, 1, 0, NL + 1);
    repeat (10) @(negedge clk);
    if (have) chk("R3", "periods per sweep", hck_cnt, cur.nper);
    chk("R3", "hck2 complement errors", compl_err, 0);
    chk("R3", "hck1 high-time errors", duty_err, 0);
    chk("R5", "gate/pchg overlap cycles", ovl_err, 0);
    chk("R5", "gate pulse count", gate_cnt, exp_gate);
    chk("R1", "unconsumed line items", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule